// File: doc/BRIEF.md
# Instruction Fetch with Indirect Address Chaining

This block loads one instruction from a character-wide memory and hands its fields to the rest of a processor. An instruction is ten consecutive characters starting on a decade boundary. The first character is the operation code and the second is the N character. The A address takes the next four characters and the B address the last four. Each character is seven bits wide, and bit 6 is an odd-parity bit. The block reads memory through a synchronous port, one character per cycle. Read data arrives one cycle after the address.

Each address is made of four decimal digits, carried in the low four bits of its characters; the most significant character comes first. Bits 5:4 of a character are its zone. A nonzero zone on the third character selects one of three index values, which is added to the address. After indexing, a zone of 01 on the last character makes the address indirect. An indirect address is then replaced by the four characters stored around the location it names. The block repeats this until the A address and then the B address are both direct. Only then does it present all fields together with a one-cycle ready pulse. An error pulse ends the fetch without ready.

Top module: `instr_fetch`

## Requirements
- R1: While reset is held and after it is released, busy, ready, rd_en and all three error outputs are 0, and op_code, n_char, a_addr and b_addr are 0.
- R2: A start pulse seen while idle reads locations start_dec*10 through start_dec*10+9 in ascending order, one per cycle. At ready, op_code and n_char carry bits 5:0 of the first and second characters.
- R3: With no indirection, the address value is 1000*d0+100*d1+10*d2+d3, where dk is bits 3:0 of character k of that address. With no indirection, ready is high in the 13th cycle after the edge that samples start.
- R4: Zone 01, 10 or 11 in bits 5:4 of the third address character adds idx1, idx2 or idx3 to the address, modulo 10000. Zone 00 adds nothing.
- R5: After indexing, zone 01 in bits 5:4 of the fourth address character marks the address as indirect, with target T. The address is replaced by the four characters at T-2, T-1, T and T+1, in that order. The replacement is indexed and tested again. A is resolved fully before B.
- R6: Each indirect step adds exactly 14 cycles to the ready latency of R3.
- R7: An indirect target that is odd or below 2 raises err_target for one cycle. That fetch gives no ready.
- R8: Any character read with an even number of ones raises err_parity for one cycle. The fetch stops and gives no ready. This applies to instruction reads and to indirect reads.
- R9: Up to 8 indirect steps per address are allowed. A ninth indirect marking on the same address raises err_loop for one cycle and gives no ready.
- R10: ready and the error flags last one cycle each, and at most one of them is high at a time. A start pulse while busy is ignored.
- R11: op_code, n_char, a_addr and b_addr change only in the cycle ready rises. A fetch that ends in an error leaves them unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a fetch (sampled when idle) |
| start_dec | input | 10 | Decade number; the instruction starts at start_dec*10 |
| idx1 | input | 14 | Index value selected by zone 01 |
| idx2 | input | 14 | Index value selected by zone 10 |
| idx3 | input | 14 | Index value selected by zone 11 |
| rd_en | output | 1 | Memory read strobe |
| rd_addr | output | 14 | Memory read address |
| rd_data | input | 7 | Character returned one cycle after rd_en |
| busy | output | 1 | A fetch is in progress |
| ready | output | 1 | One-cycle pulse: fields below are valid |
| op_code | output | 6 | Operation code information bits |
| n_char | output | 6 | N character information bits |
| a_addr | output | 14 | Resolved A address |
| b_addr | output | 14 | Resolved B address |
| err_parity | output | 1 | One-cycle pulse: parity fault |
| err_target | output | 1 | One-cycle pulse: bad indirect target |
| err_loop | output | 1 | One-cycle pulse: indirect chain too long |

## Verification
The hardest conditions to reach are the edges of the chain limit: a chain of exactly eight steps must finish, and a chain one step longer must abort. The stimulus builds a run of memory records in which each record points at the next, with the last one direct. A separate record that points at itself drives the ninth step. Indexing in the middle of a chain is covered by a stored replacement whose third character selects an index value. Parity faults on indirect reads are covered by corrupting one character of a replacement record rather than of the instruction.

// File: rtl/fetch_pkg.sv
package fetch_pkg;
  localparam int CHAR_W      = 7;
  localparam int INFO_W      = 6;
  localparam int ADDR_CHARS  = 4;
  localparam int INSTR_CHARS = 10;
  localparam int NUM_SPAN    = 10000;
  localparam int ADDR_W      = $clog2(NUM_SPAN);
  localparam int DEC_W       = $clog2(NUM_SPAN / INSTR_CHARS);

  typedef logic [CHAR_W-1:0] char_t;
  typedef logic [ADDR_CHARS-1:0][CHAR_W-1:0] addr_chars_t;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_FETCH,
    ST_RESOLVE,
    ST_INDIRECT
  } fetch_state_t;

  // A character is good when its seven bits hold an odd count of ones.
  function automatic logic odd_ok(input char_t c);
    return ^c;
  endfunction

  // Decimal value of four digit characters, most significant first.
  function automatic logic [ADDR_W-1:0] digits_value(input addr_chars_t c);
    int v;
    v = 1000 * int'(c[0][3:0]) + 100 * int'(c[1][3:0])
      + 10 * int'(c[2][3:0]) + int'(c[3][3:0]);
    return ADDR_W'(v);
  endfunction

  // Sum of two addresses folded back into the decimal span.
  function automatic logic [ADDR_W-1:0] span_add(input logic [ADDR_W-1:0] a,
                                                 input logic [ADDR_W-1:0] b);
    logic [ADDR_W:0] s;
    s = {1'b0, a} + {1'b0, b};
    if (s >= (ADDR_W+1)'(NUM_SPAN)) s = s - (ADDR_W+1)'(NUM_SPAN);
    return s[ADDR_W-1:0];
  endfunction
endpackage

// File: rtl/char_parity_chk.sv
module char_parity_chk
  import fetch_pkg::*;
(
  input  char_t ch,
  output logic  good
);
  assign good = odd_ok(ch);
endmodule

// File: rtl/addr_resolve.sv
module addr_resolve
  import fetch_pkg::*;
(
  input  addr_chars_t       chars,
  input  logic [ADDR_W-1:0] idx1,
  input  logic [ADDR_W-1:0] idx2,
  input  logic [ADDR_W-1:0] idx3,
  output logic [ADDR_W-1:0] eff,
  output logic              indirect,
  output logic              target_bad
);
  logic [ADDR_W-1:0] raw;
  logic [ADDR_W-1:0] addend;
  logic [1:0]        idx_zone;

  assign raw      = digits_value(chars);
  assign idx_zone = chars[2][5:4];

  always_comb begin
    case (idx_zone)
      2'b01:   addend = idx1;
      2'b10:   addend = idx2;
      2'b11:   addend = idx3;
      default: addend = '0;
    endcase
  end

  assign eff        = (idx_zone == 2'b00) ? raw : span_add(raw, addend);
  assign indirect   = (chars[3][5:4] == 2'b01);
  assign target_bad = eff[0] || (eff < ADDR_W'(2));

  always_comb begin
    if (idx_zone != 2'b00 && raw < ADDR_W'(NUM_SPAN) && addend < ADDR_W'(NUM_SPAN))
      AST_INDEX_IN_SPAN: assert (eff < ADDR_W'(NUM_SPAN)); // R4
  end
endmodule

// File: rtl/instr_fetch.sv
module instr_fetch
  import fetch_pkg::*;
#(
  parameter int STEP_CYC = 14,
  parameter int MAX_IND  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [DEC_W-1:0]  start_dec,
  input  logic [ADDR_W-1:0] idx1,
  input  logic [ADDR_W-1:0] idx2,
  input  logic [ADDR_W-1:0] idx3,
  output logic              rd_en,
  output logic [ADDR_W-1:0] rd_addr,
  input  logic [CHAR_W-1:0] rd_data,
  output logic              busy,
  output logic              ready,
  output logic [INFO_W-1:0] op_code,
  output logic [INFO_W-1:0] n_char,
  output logic [ADDR_W-1:0] a_addr,
  output logic [ADDR_W-1:0] b_addr,
  output logic              err_parity,
  output logic              err_target,
  output logic              err_loop
);
  // The indirect state lasts one cycle less than a step; the resolve cycle makes up the rest.
  localparam int IND_CYC = STEP_CYC - 1;
  localparam int MAXC    = (IND_CYC > INSTR_CHARS) ? IND_CYC : INSTR_CHARS;
  localparam int CNT_W   = $clog2(MAXC + 1);
  localparam int STEP_W  = $clog2(MAX_IND + 1);

  fetch_state_t      state;
  logic [CNT_W-1:0]  cnt;
  logic [ADDR_W-1:0] base_q;
  logic [ADDR_W-1:0] tgt_q;
  logic [ADDR_W-1:0] a_res_q;
  logic [STEP_W-1:0] steps;
  logic              sel_b;
  logic [INFO_W-1:0] op_q;
  logic [INFO_W-1:0] n_q;
  addr_chars_t       a_chars;
  addr_chars_t       b_chars;

  // Named internal events
  logic              cap_en;
  logic              char_good;
  logic              par_fail;
  logic [3:0]        cap_pos;
  logic [1:0]        slot_a;
  logic [1:0]        slot_b;
  logic [1:0]        slot_i;
  addr_chars_t       cur_chars;
  logic [ADDR_W-1:0] r_eff;
  logic              r_ind;
  logic              r_tgt_bad;

  assign busy    = (state != ST_IDLE);
  assign rd_en   = (state == ST_FETCH    && cnt < CNT_W'(INSTR_CHARS)) ||
                   (state == ST_INDIRECT && cnt < CNT_W'(ADDR_CHARS));
  assign rd_addr = (state == ST_FETCH) ? base_q + ADDR_W'(cnt)
                                       : tgt_q - ADDR_W'(2) + ADDR_W'(cnt);

  assign cap_en  = (state == ST_FETCH    && cnt != '0) ||
                   (state == ST_INDIRECT && cnt != '0 && cnt <= CNT_W'(ADDR_CHARS));
  assign cap_pos = 4'(cnt - CNT_W'(1));
  assign slot_a  = 2'(cap_pos - 4'd2);
  assign slot_b  = 2'(cap_pos - 4'd6);
  assign slot_i  = cap_pos[1:0];
  assign par_fail = cap_en && !char_good;
  assign cur_chars = sel_b ? b_chars : a_chars;

  char_parity_chk u_par (
    .ch   (rd_data),
    .good (char_good)
  );

  addr_resolve u_res (
    .chars      (cur_chars),
    .idx1       (idx1),
    .idx2       (idx2),
    .idx3       (idx3),
    .eff        (r_eff),
    .indirect   (r_ind),
    .target_bad (r_tgt_bad)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= ST_IDLE;
      cnt        <= '0;
      base_q     <= '0;
      tgt_q      <= '0;
      a_res_q    <= '0;
      steps      <= '0;
      sel_b      <= 1'b0;
      op_q       <= '0;
      n_q        <= '0;
      a_chars    <= '0;
      b_chars    <= '0;
      ready      <= 1'b0;
      op_code    <= '0;
      n_char     <= '0;
      a_addr     <= '0;
      b_addr     <= '0;
      err_parity <= 1'b0;
      err_target <= 1'b0;
      err_loop   <= 1'b0;
    end else begin
      ready      <= 1'b0;
      err_parity <= 1'b0;
      err_target <= 1'b0;
      err_loop   <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (start) begin
            base_q <= ADDR_W'(32'(start_dec) * INSTR_CHARS);
            cnt    <= '0;
            state  <= ST_FETCH;
          end
        end
        ST_FETCH: begin
          if (par_fail) begin
            err_parity <= 1'b1;
            state      <= ST_IDLE;
          end else begin
            if (cap_en) begin
              if (cap_pos == 4'd0)      op_q <= rd_data[INFO_W-1:0];
              else if (cap_pos == 4'd1) n_q  <= rd_data[INFO_W-1:0];
              else if (cap_pos < 4'd6)  a_chars[slot_a] <= rd_data;
              else                      b_chars[slot_b] <= rd_data;
            end
            if (cnt == CNT_W'(INSTR_CHARS)) begin
              state <= ST_RESOLVE;
              sel_b <= 1'b0;
              steps <= '0;
            end else begin
              cnt <= cnt + CNT_W'(1);
            end
          end
        end
        ST_RESOLVE: begin
          if (r_ind) begin
            if (steps == STEP_W'(MAX_IND)) begin
              err_loop <= 1'b1;
              state    <= ST_IDLE;
            end else if (r_tgt_bad) begin
              err_target <= 1'b1;
              state      <= ST_IDLE;
            end else begin
              tgt_q <= r_eff;
              steps <= steps + STEP_W'(1);
              cnt   <= '0;
              state <= ST_INDIRECT;
            end
          end else if (!sel_b) begin
            a_res_q <= r_eff;
            sel_b   <= 1'b1;
            steps   <= '0;
          end else begin
            a_addr  <= a_res_q;
            b_addr  <= r_eff;
            op_code <= op_q;
            n_char  <= n_q;
            ready   <= 1'b1;
            state   <= ST_IDLE;
          end
        end
        ST_INDIRECT: begin
          if (par_fail) begin
            err_parity <= 1'b1;
            state      <= ST_IDLE;
          end else begin
            if (cap_en) begin
              if (sel_b) b_chars[slot_i] <= rd_data;
              else        a_chars[slot_i] <= rd_data;
            end
            if (cnt == CNT_W'(IND_CYC - 1)) state <= ST_RESOLVE;
            else                            cnt   <= cnt + CNT_W'(1);
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  AST_READY_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    ready |=> !ready); // R10
  AST_ONE_OUTCOME: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ready, err_parity, err_target, err_loop})); // R10
  AST_SEQ_READS: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && $past(rd_en) && state == ST_FETCH) |-> rd_addr == $past(rd_addr) + ADDR_W'(1)); // R2
  AST_HOLD_A: assert property (@(posedge clk) disable iff (!rst_n)
    !ready |-> ($stable(a_addr) && $stable(b_addr) && $stable(op_code))); // R11
  AST_STEP_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
    steps <= STEP_W'(MAX_IND)); // R9
  AST_TARGET_EVEN: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_INDIRECT) |-> (!tgt_q[0] && tgt_q >= ADDR_W'(2))); // R7
  AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start) |=> $stable(base_q)); // R10
endmodule

// File: tb/tb_instr_fetch.sv
module tb_instr_fetch;
  import fetch_pkg::*;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              start = 1'b0;
  logic [DEC_W-1:0]  start_dec = '0;
  logic [ADDR_W-1:0] idx1 = 14'd10;
  logic [ADDR_W-1:0] idx2 = 14'd100;
  logic [ADDR_W-1:0] idx3 = 14'd25;
  logic              rd_en;
  logic [ADDR_W-1:0] rd_addr;
  logic [CHAR_W-1:0] rd_data = '0;
  logic              busy, ready, err_parity, err_target, err_loop;
  logic [INFO_W-1:0] op_code, n_char;
  logic [ADDR_W-1:0] a_addr, b_addr;

  logic [CHAR_W-1:0] mem [NUM_SPAN];
  int checks = 0;
  int fails  = 0;

  always #4 clk = ~clk;

  always_ff @(posedge clk) if (rd_en) rd_data <= mem[rd_addr];

  instr_fetch dut (
    .clk(clk), .rst_n(rst_n), .start(start), .start_dec(start_dec),
    .idx1(idx1), .idx2(idx2), .idx3(idx3),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
    .busy(busy), .ready(ready), .op_code(op_code), .n_char(n_char),
    .a_addr(a_addr), .b_addr(b_addr),
    .err_parity(err_parity), .err_target(err_target), .err_loop(err_loop)
  );

  function automatic logic [6:0] mk(input logic [5:0] info);
    return {~(^info), info};
  endfunction

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic put_addr(input int loc, input int val, input int z2, input int z3);
    mem[loc]   = mk({2'b00, 4'(val / 1000)});
    mem[loc+1] = mk({2'b00, 4'((val / 100) % 10)});
    mem[loc+2] = mk({2'(z2), 4'((val / 10) % 10)});
    mem[loc+3] = mk({2'(z3), 4'(val % 10)});
  endtask

  task automatic put_instr(input int dec, input int op, input int n,
                           input int a, input int az2, input int az3,
                           input int b, input int bz2, input int bz3);
    mem[dec*10]   = mk(6'(op));
    mem[dec*10+1] = mk(6'(n));
    put_addr(dec*10+2, a, az2, az3);
    put_addr(dec*10+6, b, bz2, bz3);
  endtask

  // outcome: 0 ready, 1 parity, 2 target, 3 loop, 4 none
  task automatic run(input int dec, output int outcome, output int lat);
    @(negedge clk);
    start = 1'b1;
    start_dec = DEC_W'(dec);
    @(negedge clk);
    start = 1'b0;
    outcome = 4;
    lat = 0;
    for (int i = 1; i <= 400; i++) begin
      @(posedge clk);
      @(negedge clk);
      lat = i;
      if (ready)           begin outcome = 0; break; end
      else if (err_parity) begin outcome = 1; break; end
      else if (err_target) begin outcome = 2; break; end
      else if (err_loop)   begin outcome = 3; break; end
    end
  endtask

  task automatic t_reset;
    check("R1 busy", int'(busy), 0);
    check("R1 ready", int'(ready), 0);
    check("R1 rd_en", int'(rd_en), 0);
    check("R1 errors", int'({err_parity, err_target, err_loop}), 0);
    check("R1 a_addr", int'(a_addr), 0);
  endtask

  task automatic t_direct;
    int oc, lat;
    put_instr(50, 6'o41, 6'o07, 1234, 0, 0, 87, 0, 0);
    run(50, oc, lat);
    check("R3 outcome", oc, 0);
    check("R3 latency", lat, 13);
    check("R2 op_code", int'(op_code), 'o41);
    check("R2 n_char", int'(n_char), 'o07);
    check("R3 a_addr", int'(a_addr), 1234);
    check("R3 b_addr", int'(b_addr), 87);
  endtask

  task automatic t_index;
    int oc, lat;
    put_instr(80, 3, 4, 1234, 1, 0, 9990, 3, 0);
    run(80, oc, lat);
    check("R4 zone01 a", int'(a_addr), 1244);
    check("R4 zone11 wrap b", int'(b_addr), 15);
    check("R4 latency", lat, 13);
    put_instr(81, 5, 6, 500, 2, 0, 3, 0, 0);
    run(81, oc, lat);
    check("R4 zone10 a", int'(a_addr), 600);
    check("R4 zone00 b", int'(b_addr), 3);
  endtask

  task automatic t_indirect;
    int oc, lat;
    put_instr(60, 9, 1, 2002, 0, 1, 100, 0, 0);
    put_addr(2000, 3456, 0, 0);
    run(60, oc, lat);
    check("R5 single a", int'(a_addr), 3456);
    check("R5 single b", int'(b_addr), 100);
    check("R6 one step latency", lat, 13 + 14);
  endtask

  task automatic t_chain;
    int oc, lat;
    put_instr(70, 2, 2, 2102, 0, 1, 2302, 0, 1);
    put_addr(2100, 2192, 1, 1);   // indexed by idx1 to 2202, still indirect
    put_addr(2200, 777, 0, 0);
    put_addr(2300, 42, 2, 0);     // indexed by idx2 to 142
    run(70, oc, lat);
    check("R5 chain a", int'(a_addr), 777);
    check("R5 chain indexed b", int'(b_addr), 142);
    check("R6 three step latency", lat, 13 + 14 * 3);
  endtask

  task automatic t_eight;
    int oc, lat;
    put_instr(120, 1, 1, 4002, 0, 1, 222, 0, 0);
    for (int i = 0; i < 7; i++) put_addr(4000 + 10 * i, 4012 + 10 * i, 0, 1);
    put_addr(4070, 1111, 0, 0);
    run(120, oc, lat);
    check("R9 eight steps outcome", oc, 0);
    check("R9 eight steps a", int'(a_addr), 1111);
    check("R6 eight step latency", lat, 13 + 14 * 8);
  endtask

  task automatic t_errors;
    int oc, lat;
    int a_prev;
    a_prev = int'(a_addr);
    put_instr(90, 1, 1, 2003, 0, 1, 5, 0, 0);
    run(90, oc, lat);
    check("R7 odd target", oc, 2);
    check("R11 unchanged after error", int'(a_addr), a_prev);
    put_instr(91, 1, 1, 1, 0, 0, 0, 0, 1);
    run(91, oc, lat);
    check("R7 target below 2 on b", oc, 2);
    put_instr(100, 1, 1, 10, 0, 0, 20, 0, 0);
    mem[1007] = mem[1007] ^ 7'h01;
    run(100, oc, lat);
    check("R8 parity in instruction", oc, 1);
    put_instr(101, 1, 1, 2402, 0, 1, 20, 0, 0);
    put_addr(2400, 1500, 0, 0);
    mem[2401] = mem[2401] ^ 7'h40;
    run(101, oc, lat);
    check("R8 parity in indirect read", oc, 1);
    put_instr(110, 1, 1, 3002, 0, 1, 20, 0, 0);
    put_addr(3000, 3002, 0, 1);
    run(110, oc, lat);
    check("R9 self loop", oc, 3);
    check("R11 unchanged after errors", int'(a_addr), a_prev);
  endtask

  task automatic t_busy_start;
    int lat;
    int pulses;
    lat = 0;
    pulses = 0;
    @(negedge clk);
    start = 1'b1;
    start_dec = DEC_W'(50);
    @(negedge clk);
    start = 1'b0;
    for (int i = 1; i <= 60; i++) begin
      if (i == 3) start = 1'b1;
      if (i == 4) start = 1'b0;
      start_dec = DEC_W'(81);
      @(posedge clk);
      @(negedge clk);
      if (ready) begin
        pulses++;
        if (lat == 0) lat = i;
      end
    end
    check("R10 start while busy latency", lat, 13);
    check("R10 single ready pulse", pulses, 1);
    check("R10 first fetch kept", int'(a_addr), 1234);
  endtask

  task automatic t_hold;
    int a_prev, b_prev;
    a_prev = int'(a_addr);
    b_prev = int'(b_addr);
    repeat (20) @(negedge clk);
    check("R11 a held", int'(a_addr), a_prev);
    check("R11 b held", int'(b_addr), b_prev);
    check("R10 ready low when idle", int'(ready), 0);
  endtask

  initial begin
    for (int i = 0; i < NUM_SPAN; i++) mem[i] = mk(6'd0);
    repeat (3) @(negedge clk);
    t_reset;
    rst_n = 1'b1;
    @(negedge clk);
    t_reset;
    t_direct;
    t_index;
    t_indirect;
    t_chain;
    t_eight;
    t_errors;
    t_busy_start;
    t_hold;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule